// File: doc/BRIEF.md
# Interpolation Mode and Field-Store Read Sequencer

This block sits in front of a vertical reconstruction datapath and decides, once per field, how the two field stores feeding that datapath are read. It samples the two control inputs `interp_on` and `film_on` and a field-parity flag on the vertical reference pulse. It resolves them into one of four operating modes and holds that choice for the whole field. It counts pixels at half the core clock rate and lines from the horizontal and vertical references.

From the mode, the field parity and the counters, it produces:
- a one-cycle read-reset strobe at each field start;
- read-enable and output-enable strobes for each of two field stores;
- a four-step coefficient phase for the filters downstream.

The first line read is delayed by a mode- and field-dependent number of lines, so that the latency through the downstream datapath stays constant from input to output. The core clock is the fast store-read clock. `half_phase` marks the pixel-rate cadence at half that rate.

Top module: `vrec_read_seq`

## Requirements
- R1: During and right after reset, `mode`, `field_even`, `half_phase`, `pix_cnt`, `line_cnt`, `rd_rst` and all four store strobes are 0.
- R2: On a clock edge with `vref` high, `mode` takes the value {`interp_on`,`film_on`}: 0 = bypass, 1 = multi-window, 2 = camera interpolation, 3 = film interpolation. Changes on those inputs while `vref` is low have no effect on `mode`.
- R3: `field_even` takes `parity_in` on a clock edge with `vref` high and holds it for the field. 0 means the first field and 1 means the second.
- R4: `half_phase` toggles every clock. `pix_cnt` advances on edges where `half_phase` was 1 and wraps from LINE_PIX-1 to 0. A clock edge with `href` high clears `pix_cnt` and `half_phase` and leaves `line_cnt` unchanged.
- R5: `line_cnt` advances by one when `pix_cnt` wraps, and it clears on a clock edge with `vref` high.
- R6: `rd_rst` is high for exactly the one clock cycle that follows a `vref` edge.
- R7: The first line read in a field is line d. In bypass d = 0 and in multi-window d = 1. In film mode d = 2 in the first field and 3 in the second. In camera mode d = 3 in the first field and 4 in the second. The first read strobe rises 2·LINE_PIX·d+1 clocks after the `vref` edge.
- R8: Reads cover ACTIVE_LINES consecutive lines from line d. In each of those lines they cover pixels 0 to ACTIVE_PIX-1, which is 2·ACTIVE_PIX clocks per line.
- R9: In bypass only store A is read. In multi-window mode, relative lines 0, 2, 4… come from A and lines 1, 3… from B. In camera and film modes the first field is read from A and the second from B. The two read strobes are never high together.
- R10: Each output enable follows its store's read enable one clock later, with the same number of high cycles.
- R11: `coef_phase` equals (`line_cnt` − d) mod 4, so it is 0 on the first read line and 1 on the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock (field-store read rate) |
| rst_n | input | 1 | Asynchronous active-low reset |
| href | input | 1 | Horizontal reference, resynchronizes the pixel counter |
| vref | input | 1 | Vertical reference, starts a field |
| interp_on | input | 1 | Interpolation request |
| film_on | input | 1 | Film/multi-window qualifier |
| parity_in | input | 1 | Field parity from the upstream stage |
| mode | output | 2 | Latched operating mode |
| field_even | output | 1 | Realigned field parity |
| half_phase | output | 1 | Pixel-rate phase (pixel advances when 1) |
| pix_cnt | output | $clog2(LINE_PIX) | Pixel counter |
| line_cnt | output | LINE_W | Line counter within field |
| coef_phase | output | 2 | Filter coefficient phase |
| rd_rst | output | 1 | Field-store read reset strobe |
| rd_en_a | output | 1 | Read enable, store A |
| rd_en_b | output | 1 | Read enable, store B |
| out_en_a | output | 1 | Output enable, store A |
| out_en_b | output | 1 | Output enable, store B |

## Verification
A wrong latched mode or parity shows up at the `vref` edge itself, on `mode` and `field_even`. It then shows up 2·LINE_PIX·d+1 clocks later as a read strobe rising on the wrong line or on the wrong store. A miscount in the pixel or line counters moves the read window and changes the number of strobe cycles per field. That error is visible within one line, and it is confirmed by the strobe counts at the end of the field. An output enable that does not track its read enable is visible one clock after the first read.

// File: rtl/vrec_read_seq.sv
module vrec_read_seq #(
  parameter int LINE_PIX     = 1024,
  parameter int ACTIVE_PIX   = 720,
  parameter int ACTIVE_LINES = 288,
  parameter int LINE_W       = 10
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        href,
  input  logic                        vref,
  input  logic                        interp_on,
  input  logic                        film_on,
  input  logic                        parity_in,
  output logic [1:0]                  mode,
  output logic                        field_even,
  output logic                        half_phase,
  output logic [$clog2(LINE_PIX)-1:0] pix_cnt,
  output logic [LINE_W-1:0]           line_cnt,
  output logic [1:0]                  coef_phase,
  output logic                        rd_rst,
  output logic                        rd_en_a,
  output logic                        rd_en_b,
  output logic                        out_en_a,
  output logic                        out_en_b
);
  localparam int PIX_W = $clog2(LINE_PIX);
  localparam logic [PIX_W-1:0]  PIX_LAST = PIX_W'(LINE_PIX - 1);
  localparam logic [PIX_W-1:0]  PIX_ACT  = PIX_W'(ACTIVE_PIX);
  localparam logic [LINE_W-1:0] LIN_ACT  = LINE_W'(ACTIVE_LINES);

  localparam logic [1:0] M_BYP = 2'd0, M_PIP = 2'd1, M_CAM = 2'd2, M_FILM = 2'd3;

  logic [LINE_W-1:0] start_line, rel_line;
  logic              in_win, pick_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode       <= M_BYP;
      field_even <= 1'b0;
      half_phase <= 1'b0;
      pix_cnt    <= '0;
      line_cnt   <= '0;
    end else if (vref) begin
      mode       <= {interp_on, film_on};
      field_even <= parity_in;
      half_phase <= 1'b0;
      pix_cnt    <= '0;
      line_cnt   <= '0;
    end else if (href) begin
      half_phase <= 1'b0;
      pix_cnt    <= '0;
    end else begin
      half_phase <= ~half_phase;
      if (half_phase) begin
        if (pix_cnt == PIX_LAST) begin
          pix_cnt  <= '0;
          line_cnt <= line_cnt + 1'b1;
        end else begin
          pix_cnt <= pix_cnt + 1'b1;
        end
      end
    end
  end

  always_comb begin
    case (mode)
      M_BYP:   start_line = LINE_W'(0);
      M_PIP:   start_line = LINE_W'(1);
      M_CAM:   start_line = field_even ? LINE_W'(4) : LINE_W'(3);
      default: start_line = field_even ? LINE_W'(3) : LINE_W'(2);
    endcase
  end

  assign rel_line   = line_cnt - start_line;
  assign coef_phase = rel_line[1:0];
  assign in_win     = (line_cnt >= start_line) && (rel_line < LIN_ACT) && (pix_cnt < PIX_ACT);

  always_comb begin
    case (mode)
      M_BYP:   pick_b = 1'b0;
      M_PIP:   pick_b = rel_line[0];
      default: pick_b = field_even;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_rst   <= 1'b0;
      rd_en_a  <= 1'b0;
      rd_en_b  <= 1'b0;
      out_en_a <= 1'b0;
      out_en_b <= 1'b0;
    end else begin
      rd_rst   <= vref;
      rd_en_a  <= in_win & ~pick_b;
      rd_en_b  <= in_win & pick_b;
      out_en_a <= rd_en_a;
      out_en_b <= rd_en_b;
    end
  end

  AST_PIX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    pix_cnt <= PIX_LAST); // R4
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !vref |=> $stable(mode)); // R2
  AST_PARITY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !vref |=> $stable(field_even)); // R3
  AST_RST_AT_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rst |-> (line_cnt == '0 && pix_cnt == '0)); // R6
  AST_ONE_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_en_a, rd_en_b})); // R9
  AST_READ_IN_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_a || rd_en_b) |-> $past(pix_cnt) < PIX_ACT); // R8
  AST_OE_TRAILS_A: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_en_a) |-> $past(rd_en_a)); // R10
  AST_OE_TRAILS_B: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_en_b) |-> $past(rd_en_b)); // R10
endmodule

// File: tb/vrec_read_seq_bench.sv
module vrec_read_seq_bench;
  localparam int LP = 8, AP = 6, AL = 3, LW = 10;
  localparam int FIELD_CLK = 2 * LP * 8;

  logic clk = 0, rst_n = 0, href = 0, vref = 0, interp_on = 0, film_on = 0, parity_in = 0;
  logic [1:0] mode, coef_phase;
  logic field_even, half_phase, rd_rst, rd_en_a, rd_en_b, out_en_a, out_en_b;
  logic [$clog2(LP)-1:0] pix_cnt;
  logic [LW-1:0] line_cnt;

  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  vrec_read_seq #(.LINE_PIX(LP), .ACTIVE_PIX(AP), .ACTIVE_LINES(AL), .LINE_W(LW)) u_vrec_read_seq (
    .clk(clk), .rst_n(rst_n), .href(href), .vref(vref), .interp_on(interp_on), .film_on(film_on),
    .parity_in(parity_in), .mode(mode), .field_even(field_even), .half_phase(half_phase),
    .pix_cnt(pix_cnt), .line_cnt(line_cnt), .coef_phase(coef_phase), .rd_rst(rd_rst),
    .rd_en_a(rd_en_a), .rd_en_b(rd_en_b), .out_en_a(out_en_a), .out_en_b(out_en_b));

  // stimulus code = interp*4 + film*2 + parity; expected start line, lines from A, lines from B
  localparam int V_IN[8] = '{0, 1, 2, 3, 4, 5, 6, 7};
  localparam int V_D[8]  = '{0, 0, 1, 1, 3, 4, 2, 3};
  localparam int V_LA[8] = '{3, 3, 2, 2, 3, 0, 3, 0};
  localparam int V_LB[8] = '{0, 0, 1, 1, 0, 3, 0, 3};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({mode, field_even, half_phase, pix_cnt, line_cnt, rd_rst, rd_en_a, rd_en_b, out_en_a, out_en_b} == '0,
        "R1 reset outputs", int'(line_cnt), 0);
    rst_n = 1;
    repeat (FIELD_CLK + 4) @(negedge clk);

    for (int v = 0; v < 8; v++) begin
      int fa, fb, foa, fob, ca, cb, coa, cob, d;
      d = V_D[v];
      fa = -1; fb = -1; foa = -1; fob = -1; ca = 0; cb = 0; coa = 0; cob = 0;
      interp_on = V_IN[v][2]; film_on = V_IN[v][1]; parity_in = V_IN[v][0];
      vref = 1;
      @(negedge clk);
      vref = 0;
      interp_on = ~interp_on; film_on = ~film_on; parity_in = ~parity_in;
      chk(mode == 2'(V_IN[v] >> 1), "R2 mode latched", int'(mode), V_IN[v] >> 1);
      chk(field_even == V_IN[v][0], "R3 parity latched", int'(field_even), V_IN[v] & 1);
      chk(rd_rst == 1'b1, "R6 read reset high", int'(rd_rst), 1);
      for (int k = 0; k < FIELD_CLK; k++) begin
        if (k > 0) @(negedge clk);
        if (k == 1) chk(rd_rst == 1'b0, "R6 read reset one cycle", int'(rd_rst), 0);
        if (k == 2 * LP - 1) chk(pix_cnt == LP - 1 && line_cnt == 0, "R4 last pixel", int'(pix_cnt), LP - 1);
        if (k == 2 * LP) chk(pix_cnt == 0 && line_cnt == 1, "R5 line advance on wrap", int'(line_cnt), 1);
        if (k == 2 * LP * d + 1) chk(coef_phase == 2'd0, "R11 phase first line", int'(coef_phase), 0);
        if (k == 2 * LP * (d + 1) + 1) chk(coef_phase == 2'd1, "R11 phase second line", int'(coef_phase), 1);
        if (rd_en_a) begin ca++; if (fa < 0) fa = k; end
        if (rd_en_b) begin cb++; if (fb < 0) fb = k; end
        if (out_en_a) begin coa++; if (foa < 0) foa = k; end
        if (out_en_b) begin cob++; if (fob < 0) fob = k; end
        if (rd_en_a && rd_en_b) chk(1'b0, "R9 both stores read", 1, 0);
      end
      chk(mode == 2'(V_IN[v] >> 1), "R2 mode ignores mid-field inputs", int'(mode), V_IN[v] >> 1);
      chk(field_even == V_IN[v][0], "R3 parity held", int'(field_even), V_IN[v] & 1);
      if (V_LA[v] > 0) begin
        chk(fa == 2 * LP * d + 1, "R7 first read store A", fa, 2 * LP * d + 1);
        chk(foa == fa + 1, "R10 out enable A trails", foa, fa + 1);
      end else begin
        chk(fb == 2 * LP * d + 1, "R7 first read store B", fb, 2 * LP * d + 1);
        chk(fob == fb + 1, "R10 out enable B trails", fob, fb + 1);
      end
      chk(ca == V_LA[v] * 2 * AP, "R9 store A read cycles", ca, V_LA[v] * 2 * AP);
      chk(cb == V_LB[v] * 2 * AP, "R9 store B read cycles", cb, V_LB[v] * 2 * AP);
      chk(ca + cb == AL * 2 * AP, "R8 total read cycles", ca + cb, AL * 2 * AP);
      chk(coa == ca && cob == cb, "R10 out enable counts", coa + cob, ca + cb);
    end

    // R4 href resync: mid-line clear of pixel counter and phase, line kept
    begin
      logic [LW-1:0] ln;
      vref = 1; @(negedge clk); vref = 0;
      repeat (2 * LP + 7) @(negedge clk);
      ln = line_cnt;
      chk(pix_cnt != 0, "R4 pixel nonzero before href", int'(pix_cnt), 1);
      href = 1; @(negedge clk); href = 0;
      chk(pix_cnt == 0 && half_phase == 0, "R4 href clears pixel", int'(pix_cnt), 0);
      chk(line_cnt == ln, "R4 href keeps line", int'(line_cnt), int'(ln));
      @(negedge clk);
      chk(half_phase == 1 && pix_cnt == 0, "R4 half phase toggles", int'(half_phase), 1);
      @(negedge clk);
      chk(pix_cnt == 1, "R4 pixel advances every second clock", int'(pix_cnt), 1);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule